// File: doc/BRIEF.md
# Lockable GPIO Register Bank

This block is the software-facing register file of a GPIO controller. It decodes a 4 KiB window of aligned 32-bit words and keeps the per-pin configuration for the pin and event logic beside it: polarity, output value, output enable, open-drain type, pull-up and pull-down, input mask, event type and both-edge selection, event enable and event status. Output value, output enable and event enable each have a write-only set alias and a write-only clear alias, so software can change single bits without a read-modify-write. Several settings (pin function, debounce, four blink words, slew rate, drive strength) are only stored and read back. The per-pin lock words read as zero and ignore writes.

The pin logic supplies the conditioned input level, which is read through the data-in word. The event logic raises bits in the event status word, and software clears them by writing ones. A global lock freezes every register. It is engaged by any write to either lock word and released only by a two-step sequence: an arming value goes into the second lock word, then a key value goes into the first. Every access gets its response in the following cycle, and an error strobe marks accesses the bank refuses.

Top module: `gpio_regbank`

## Requirements
- R1: After reset every register reads zero, except pull-up (offset 0x1C), pull-down (0x20), slew (0x5C) and drive strength (0x60), which read the reset parameters PU_RST, PD_RST, SLEW_RST and DRV_RST. The bank comes out of reset unlocked, with `locked` low and offset 0x00 reading 0.
- R2: While unlocked, a write to a plain register stores the value, and a later read returns it. The plain registers are polarity 0x08, data-out 0x0C, output-enable 0x10, output-type 0x14, function 0x18, pull-up 0x1C, pull-down 0x20, debounce 0x24, event-type 0x28, both-edge 0x2C, blink 0x30/0x34/0x38/0x3C, event-enable 0x40, input-mask 0x58, slew 0x5C and drive 0x60. The matching `cfg_*` output shows the value from the cycle after the write.
- R3: Set aliases OR the written value into their target, and clear aliases AND their target with the inverted value. The pairs are data-out set 0x68 / clear 0x6C, output-enable set 0x70 / clear 0x74, and event-enable set 0x44 / clear 0x48. Reading an alias returns zero and raises the error strobe.
- R4: An event status bit (offset 0x4C, output `evt_status`) is set in the cycle after its `evt_hit` bit is high, and stays set until software writes a 1 to it. Bits written as 0 are unaffected. If a hit and a clear of the same bit arrive in one cycle, the bit stays set.
- R5: Offset 0x04 reads the current `pin_in` value. A write to 0x04 changes nothing and raises the error strobe.
- R6: While unlocked, a write of any value to offset 0x00 or offset 0x7C engages the lock. From the next cycle `locked` is high and 0x00 reads 1, and the second lock word is cleared, even when the written value was the arming value.
- R7: While locked, a write to any register other than the two lock words leaves every register unchanged, including event status, and raises the error strobe. Reads still work, and hardware events still set status bits.
- R8: While locked, a write to 0x7C stores the value. A write of 0xC0DEFA73 to 0x00 while 0x7C holds 0xC0DE1248 releases the lock and clears both words. A write of any other value to 0x00, or any write without the arming value in place, leaves the bank locked. The second lock word always reads zero.
- R9: A misaligned address, or an address that maps to no register, reads zero and ignores writes, and the access raises the error strobe. The per-pin lock words 0x50 and 0x54 read zero and ignore writes, without raising the error strobe.
- R10: `bus_rdata` and `bus_err` respond in the cycle after `bus_valid`. `bus_err` is never high in a cycle that follows a cycle with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle strobe for a refused access |
| pin_in | input | NPINS | Conditioned input levels from the pin logic |
| evt_hit | input | NPINS | Per-pin event detections from the event logic |
| cfg_pol | output | NPINS | Polarity inversion |
| cfg_dout | output | NPINS | Output data |
| cfg_oe | output | NPINS | Output enable |
| cfg_otype | output | NPINS | Open-drain select |
| cfg_pullup | output | NPINS | Pull-up enable |
| cfg_pulldown | output | NPINS | Pull-down enable |
| cfg_inmask | output | NPINS | Input mask |
| cfg_evtype | output | NPINS | Event type (0 level, 1 edge) |
| cfg_evboth | output | NPINS | Both-edge select |
| cfg_even | output | NPINS | Event enable |
| evt_status | output | NPINS | Event status bits |
| locked | output | 1 | Global lock engaged |

## Verification
The bench builds the bank with 32 pins and four distinct non-zero reset masks for pull-up, pull-down, slew and drive. This makes reset loading visible per register and lets a swapped or missing reset value show up on a plain read. The default key and arming values are kept, so the lock tests exercise the exact handshake, the arming value written as an engaging write, and a wrong key. With full 32-bit registers, set and clear aliases can be checked on patterns that touch both halves of the word.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

  typedef enum logic [5:0] {
    ID_LOCKA, ID_DIN, ID_POL, ID_DOUT, ID_OE, ID_OTYP, ID_FUNC, ID_PU, ID_PD,
    ID_DBNC, ID_EVTYP, ID_EVBOTH, ID_BLK0, ID_BLK1, ID_BLK2, ID_BLK3,
    ID_EVEN, ID_EVEN_SET, ID_EVEN_CLR, ID_EVST, ID_PPLK0, ID_PPLK1,
    ID_INMASK, ID_SLEW, ID_DRV, ID_DOUT_SET, ID_DOUT_CLR, ID_OE_SET,
    ID_OE_CLR, ID_LOCKB, ID_NONE
  } reg_id_t;

  // stored configuration words, index order inside the bank
  localparam int NSTORE    = 18;
  localparam int IX_POL    = 0;
  localparam int IX_DOUT   = 1;
  localparam int IX_OE     = 2;
  localparam int IX_OTYP   = 3;
  localparam int IX_FUNC   = 4;
  localparam int IX_PU     = 5;
  localparam int IX_PD     = 6;
  localparam int IX_DBNC   = 7;
  localparam int IX_EVTYP  = 8;
  localparam int IX_EVBOTH = 9;
  localparam int IX_BLK0   = 10;
  localparam int IX_EVEN   = 14;
  localparam int IX_INMASK = 15;
  localparam int IX_SLEW   = 16;
  localparam int IX_DRV    = 17;

  function automatic reg_id_t store_id(input int k);
    case (k)
      IX_POL:    return ID_POL;
      IX_DOUT:   return ID_DOUT;
      IX_OE:     return ID_OE;
      IX_OTYP:   return ID_OTYP;
      IX_FUNC:   return ID_FUNC;
      IX_PU:     return ID_PU;
      IX_PD:     return ID_PD;
      IX_DBNC:   return ID_DBNC;
      IX_EVTYP:  return ID_EVTYP;
      IX_EVBOTH: return ID_EVBOTH;
      10:        return ID_BLK0;
      11:        return ID_BLK1;
      12:        return ID_BLK2;
      13:        return ID_BLK3;
      IX_EVEN:   return ID_EVEN;
      IX_INMASK: return ID_INMASK;
      IX_SLEW:   return ID_SLEW;
      default:   return ID_DRV;
    endcase
  endfunction

  function automatic reg_id_t set_alias(input reg_id_t id);
    case (id)
      ID_DOUT: return ID_DOUT_SET;
      ID_OE:   return ID_OE_SET;
      ID_EVEN: return ID_EVEN_SET;
      default: return ID_NONE;
    endcase
  endfunction

  function automatic reg_id_t clr_alias(input reg_id_t id);
    case (id)
      ID_DOUT: return ID_DOUT_CLR;
      ID_OE:   return ID_OE_CLR;
      ID_EVEN: return ID_EVEN_CLR;
      default: return ID_NONE;
    endcase
  endfunction

  // word index (byte offset / 4) to register
  function automatic reg_id_t word_to_id(input logic [4:0] w);
    case (w)
      5'h00: return ID_LOCKA;
      5'h01: return ID_DIN;
      5'h02: return ID_POL;
      5'h03: return ID_DOUT;
      5'h04: return ID_OE;
      5'h05: return ID_OTYP;
      5'h06: return ID_FUNC;
      5'h07: return ID_PU;
      5'h08: return ID_PD;
      5'h09: return ID_DBNC;
      5'h0A: return ID_EVTYP;
      5'h0B: return ID_EVBOTH;
      5'h0C: return ID_BLK0;
      5'h0D: return ID_BLK1;
      5'h0E: return ID_BLK2;
      5'h0F: return ID_BLK3;
      5'h10: return ID_EVEN;
      5'h11: return ID_EVEN_SET;
      5'h12: return ID_EVEN_CLR;
      5'h13: return ID_EVST;
      5'h14: return ID_PPLK0;
      5'h15: return ID_PPLK1;
      5'h16: return ID_INMASK;
      5'h17: return ID_SLEW;
      5'h18: return ID_DRV;
      5'h1A: return ID_DOUT_SET;
      5'h1B: return ID_DOUT_CLR;
      5'h1C: return ID_OE_SET;
      5'h1D: return ID_OE_CLR;
      5'h1F: return ID_LOCKB;
      default: return ID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regbank_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic          is_locked,
  output reg_id_t       acc_id,
  output logic          acc_refused,
  output logic          acc_wr_ok
);
  localparam int HI_W = AW - 7;

  logic    in_range;
  logic    write_only;
  logic    is_lock_word;
  reg_id_t id_raw;

  always_comb begin
    in_range     = (acc_addr[1:0] == 2'b00) && (acc_addr[AW-1:7] == {HI_W{1'b0}});
    id_raw       = word_to_id(acc_addr[6:2]);
    acc_id       = in_range ? id_raw : ID_NONE;
    write_only   = (acc_id inside {ID_EVEN_SET, ID_EVEN_CLR, ID_DOUT_SET, ID_DOUT_CLR,
                                   ID_OE_SET, ID_OE_CLR, ID_LOCKB});
    is_lock_word = (acc_id == ID_LOCKA) || (acc_id == ID_LOCKB);
    acc_refused  = acc_valid && ((acc_id == ID_NONE)
                               || (acc_write && acc_id == ID_DIN)
                               || (!acc_write && write_only)
                               || (acc_write && is_locked && !is_lock_word));
    acc_wr_ok    = acc_valid && acc_write && !acc_refused;
  end
endmodule

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl #(
  parameter logic [31:0] KEY_VAL = 32'hC0DE_FA73,
  parameter logic [31:0] ARM_VAL = 32'hC0DE_1248
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_first,
  input  logic        wr_second,
  input  logic [31:0] wdata,
  output logic        lock_on
);
  logic        lock_q, lock_d;
  logic [31:0] arm_q, arm_d;
  logic        arm_en;

  always_comb begin
    lock_d = lock_q;
    arm_d  = arm_q;
    if (!lock_q) begin
      if (wr_first || wr_second) begin
        lock_d = 1'b1;
        arm_d  = '0;
      end
    end else if (wr_second) begin
      arm_d = wdata;
    end else if (wr_first && (wdata == KEY_VAL) && (arm_q == ARM_VAL)) begin
      lock_d = 1'b0;
      arm_d  = '0;
    end
    arm_en = wr_first || wr_second;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      arm_q  <= '0;
    end else if (arm_en) begin
      lock_q <= lock_d;
      arm_q  <= arm_d;
    end
  end

  assign lock_on = lock_q;
endmodule

// File: rtl/gpio_reg_cell.sv
module gpio_reg_cell #(
  parameter int            W      = 32,
  parameter logic [W-1:0]  RSTVAL = '0,
  parameter bit            W1C    = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_load,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_d;
  logic         en;

  generate
    if (W1C) begin : g_w1c
      always_comb begin
        q_d = (q_r & ~(wr_clr ? wdata : {W{1'b0}})) | hw_set;
        en  = wr_clr || (hw_set != '0);
      end
    end else begin : g_plain
      always_comb begin
        q_d = q_r;
        if (wr_load)     q_d = wdata;
        else if (wr_set) q_d = q_r | wdata;
        else if (wr_clr) q_d = q_r & ~wdata;
        en = wr_load || wr_set || wr_clr;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= RSTVAL;
    else if (en) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int              NPINS    = 32,
  parameter int              AW       = 12,
  parameter logic [NPINS-1:0] PU_RST   = '0,
  parameter logic [NPINS-1:0] PD_RST   = '0,
  parameter logic [NPINS-1:0] SLEW_RST = '0,
  parameter logic [NPINS-1:0] DRV_RST  = '0,
  parameter logic [31:0]     KEY_VAL  = 32'hC0DE_FA73,
  parameter logic [31:0]     ARM_VAL  = 32'hC0DE_1248
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_err,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] evt_hit,
  output logic [NPINS-1:0] cfg_pol,
  output logic [NPINS-1:0] cfg_dout,
  output logic [NPINS-1:0] cfg_oe,
  output logic [NPINS-1:0] cfg_otype,
  output logic [NPINS-1:0] cfg_pullup,
  output logic [NPINS-1:0] cfg_pulldown,
  output logic [NPINS-1:0] cfg_inmask,
  output logic [NPINS-1:0] cfg_evtype,
  output logic [NPINS-1:0] cfg_evboth,
  output logic [NPINS-1:0] cfg_even,
  output logic [NPINS-1:0] evt_status,
  output logic             locked
);
  localparam int PAD = 32 - NPINS;

  reg_id_t          acc_id;
  logic             refused, wr_ok, lock_on;
  logic [NPINS-1:0] wdat;
  logic [NPINS-1:0] store_q [NSTORE];
  logic [NPINS-1:0] evst_q;
  logic [31:0]      rd_mux, rdata_q, rdata_d;
  logic             err_q, rd_en;

  assign wdat = bus_wdata[NPINS-1:0];

  gpio_addr_decode #(.AW(AW)) u_dec (
    .acc_valid(bus_valid), .acc_write(bus_write), .acc_addr(bus_addr),
    .is_locked(lock_on), .acc_id(acc_id), .acc_refused(refused), .acc_wr_ok(wr_ok)
  );

  gpio_lock_ctrl #(.KEY_VAL(KEY_VAL), .ARM_VAL(ARM_VAL)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .wr_first(wr_ok && acc_id == ID_LOCKA),
    .wr_second(wr_ok && acc_id == ID_LOCKB),
    .wdata(bus_wdata), .lock_on(lock_on)
  );

  for (genvar k = 0; k < NSTORE; k++) begin : g_store
    localparam reg_id_t RID = store_id(k);
    localparam logic [NPINS-1:0] RV =
      (RID == ID_PU)   ? PU_RST   :
      (RID == ID_PD)   ? PD_RST   :
      (RID == ID_SLEW) ? SLEW_RST :
      (RID == ID_DRV)  ? DRV_RST  : {NPINS{1'b0}};
    gpio_reg_cell #(.W(NPINS), .RSTVAL(RV), .W1C(1'b0)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .wr_load(wr_ok && acc_id == RID),
      .wr_set(wr_ok && acc_id == set_alias(RID)),
      .wr_clr(wr_ok && acc_id == clr_alias(RID)),
      .wdata(wdat), .hw_set({NPINS{1'b0}}), .q(store_q[k])
    );
  end

  gpio_reg_cell #(.W(NPINS), .RSTVAL({NPINS{1'b0}}), .W1C(1'b1)) u_evst (
    .clk(clk), .rst_n(rst_n),
    .wr_load(1'b0), .wr_set(1'b0),
    .wr_clr(wr_ok && acc_id == ID_EVST),
    .wdata(wdat), .hw_set(evt_hit), .q(evst_q)
  );

  // read path
  always_comb begin
    rd_mux = '0;
    case (acc_id)
      ID_LOCKA: rd_mux = {31'd0, lock_on};
      ID_DIN:   rd_mux = {{PAD{1'b0}}, pin_in};
      ID_EVST:  rd_mux = {{PAD{1'b0}}, evst_q};
      default: begin
        for (int k = 0; k < NSTORE; k++)
          if (acc_id == store_id(k)) rd_mux = {{PAD{1'b0}}, store_q[k]};
      end
    endcase
    rd_en   = bus_valid && !bus_write;
    rdata_d = refused ? 32'd0 : rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= refused;
  end

  assign bus_rdata    = rdata_q;
  assign bus_err      = err_q;
  assign locked       = lock_on;
  assign evt_status   = evst_q;
  assign cfg_pol      = store_q[IX_POL];
  assign cfg_dout     = store_q[IX_DOUT];
  assign cfg_oe       = store_q[IX_OE];
  assign cfg_otype    = store_q[IX_OTYP];
  assign cfg_pullup   = store_q[IX_PU];
  assign cfg_pulldown = store_q[IX_PD];
  assign cfg_inmask   = store_q[IX_INMASK];
  assign cfg_evtype   = store_q[IX_EVTYP];
  assign cfg_evboth   = store_q[IX_EVBOTH];
  assign cfg_even     = store_q[IX_EVEN];
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_rdata,
  input logic             bus_err,
  input logic             locked,
  input logic [NPINS-1:0] cfg_dout,
  input logic [NPINS-1:0] cfg_oe,
  input logic [NPINS-1:0] cfg_pol,
  input logic [NPINS-1:0] evt_hit,
  input logic [NPINS-1:0] evt_status
);
  localparam logic [AW-1:0] A_LOCKA = '0;
  localparam logic [AW-1:0] A_LOCKB = AW'(12'h07C);
  localparam logic [AW-1:0] A_TOP   = {{(AW-2){1'b1}}, 2'b00};

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !bus_err);

  assert_lock_engage_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && bus_valid && bus_write && (bus_addr == A_LOCKA || bus_addr == A_LOCKB))
    |=> locked);

  assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(bus_valid && bus_write && bus_addr == A_LOCKA)) |=> locked);

  assert_frozen_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(cfg_dout) && $stable(cfg_oe) && $stable(cfg_pol)));

  assert_hit_captured_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit != '0) |=> ((evt_status & $past(evt_hit)) == $past(evt_hit)));

  assert_status_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (($past(evt_status) & ~evt_status) == '0));

  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == A_TOP) |=> (bus_rdata == 32'd0 && bus_err));
endmodule

bind gpio_regbank gpio_regbank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .locked(locked), .cfg_dout(cfg_dout), .cfg_oe(cfg_oe), .cfg_pol(cfg_pol),
  .evt_hit(evt_hit), .evt_status(evt_status)
);

// File: tb/sim_gpio_regbank.sv
`timescale 1ns/1ps
module sim_gpio_regbank;
  localparam int          NPINS = 32;
  localparam int          AW    = 12;
  localparam logic [31:0] PU_V  = 32'hA5A5_0F0F;
  localparam logic [31:0] PD_V  = 32'h0000_FF00;
  localparam logic [31:0] SL_V  = 32'h1234_5678;
  localparam logic [31:0] DR_V  = 32'h8000_0001;
  localparam logic [31:0] KEY   = 32'hC0DE_FA73;
  localparam logic [31:0] ARM   = 32'hC0DE_1248;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_err, locked;
  logic [NPINS-1:0] pin_in = '0, evt_hit = '0;
  logic [NPINS-1:0] cfg_pol, cfg_dout, cfg_oe, cfg_otype, cfg_pullup, cfg_pulldown;
  logic [NPINS-1:0] cfg_inmask, cfg_evtype, cfg_evboth, cfg_even, evt_status;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_regbank #(.NPINS(NPINS), .AW(AW), .PU_RST(PU_V), .PD_RST(PD_V),
                 .SLEW_RST(SL_V), .DRV_RST(DR_V)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .pin_in(pin_in), .evt_hit(evt_hit), .cfg_pol(cfg_pol),
    .cfg_dout(cfg_dout), .cfg_oe(cfg_oe), .cfg_otype(cfg_otype),
    .cfg_pullup(cfg_pullup), .cfg_pulldown(cfg_pulldown), .cfg_inmask(cfg_inmask),
    .cfg_evtype(cfg_evtype), .cfg_evboth(cfg_evboth), .cfg_even(cfg_even),
    .evt_status(evt_status), .locked(locked)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one access; result sampled at the negedge after the responding posedge
  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    rd = bus_rdata; er = bus_err;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic exp_err,
                    input string req);
    logic [31:0] rd; logic er;
    access(1'b1, a, d, rd, er);
    check({req, " write err"}, {31'd0, er}, {31'd0, exp_err});
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp,
                        input logic exp_err, input string req);
    logic [31:0] rd; logic er;
    access(1'b0, a, 32'd0, rd, er);
    check({req, " read data"}, rd, exp);
    check({req, " read err"}, {31'd0, er}, {31'd0, exp_err});
  endtask

  task automatic pulse_hit(input logic [31:0] m);
    @(negedge clk); evt_hit = m;
    @(negedge clk); evt_hit = '0;
  endtask

  task automatic t_reset;
    check("R1 locked low", {31'd0, locked}, 32'd0);
    rd_chk(12'h000, 32'd0, 1'b0, "R1 lock word");
    rd_chk(12'h01C, PU_V, 1'b0, "R1 pull-up");
    rd_chk(12'h020, PD_V, 1'b0, "R1 pull-down");
    rd_chk(12'h05C, SL_V, 1'b0, "R1 slew");
    rd_chk(12'h060, DR_V, 1'b0, "R1 drive");
    rd_chk(12'h00C, 32'd0, 1'b0, "R1 data-out");
    rd_chk(12'h04C, 32'd0, 1'b0, "R1 status");
  endtask

  task automatic t_plain;
    wr(12'h008, 32'hF0F0_1234, 1'b0, "R2 polarity");
    check("R2 cfg_pol", cfg_pol, 32'hF0F0_1234);
    rd_chk(12'h008, 32'hF0F0_1234, 1'b0, "R2 polarity");
    wr(12'h038, 32'hDEAD_BEEF, 1'b0, "R2 blink2");
    rd_chk(12'h038, 32'hDEAD_BEEF, 1'b0, "R2 blink2");
    wr(12'h058, 32'h0000_FFFF, 1'b0, "R2 inmask");
    check("R2 cfg_inmask", cfg_inmask, 32'h0000_FFFF);
    wr(12'h01C, 32'h1111_0000, 1'b0, "R2 pull-up");
    check("R2 cfg_pullup", cfg_pullup, 32'h1111_0000);
  endtask

  task automatic t_alias;
    wr(12'h00C, 32'h0000_00FF, 1'b0, "R3 dout base");
    wr(12'h068, 32'h0F00_0000, 1'b0, "R3 dout set");
    rd_chk(12'h00C, 32'h0F00_00FF, 1'b0, "R3 dout after set");
    wr(12'h06C, 32'h0000_000F, 1'b0, "R3 dout clear");
    check("R3 cfg_dout", cfg_dout, 32'h0F00_00F0);
    rd_chk(12'h068, 32'd0, 1'b1, "R3 set alias reads zero");
    wr(12'h070, 32'h0000_0003, 1'b0, "R3 oe set");
    wr(12'h074, 32'h0000_0001, 1'b0, "R3 oe clear");
    check("R3 cfg_oe", cfg_oe, 32'h0000_0002);
    wr(12'h044, 32'h8000_0001, 1'b0, "R3 even set");
    wr(12'h048, 32'h0000_0001, 1'b0, "R3 even clear");
    check("R3 cfg_even", cfg_even, 32'h8000_0000);
    rd_chk(12'h040, 32'h8000_0000, 1'b0, "R3 even readback");
  endtask

  task automatic t_events;
    pulse_hit(32'h0000_0011);
    check("R4 status after hit", evt_status, 32'h0000_0011);
    wr(12'h04C, 32'h0000_0001, 1'b0, "R4 w1c");
    rd_chk(12'h04C, 32'h0000_0010, 1'b0, "R4 partial clear");
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h04C; bus_wdata = 32'h10;
    evt_hit = 32'h10;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; evt_hit = '0;
    check("R4 hit beats clear", evt_status, 32'h0000_0010);
    wr(12'h04C, 32'h0000_0010, 1'b0, "R4 final clear");
    check("R4 status empty", evt_status, 32'd0);
  endtask

  task automatic t_din;
    pin_in = 32'h5A5A_0001;
    rd_chk(12'h004, 32'h5A5A_0001, 1'b0, "R5 data-in");
    wr(12'h004, 32'hFFFF_FFFF, 1'b1, "R5 data-in write");
    rd_chk(12'h004, 32'h5A5A_0001, 1'b0, "R5 data-in after write");
  endtask

  task automatic t_lock;
    wr(12'h07C, ARM, 1'b0, "R6 engage via second word");
    check("R6 locked", {31'd0, locked}, 32'd1);
    rd_chk(12'h000, 32'd1, 1'b0, "R6 lock word");
    rd_chk(12'h07C, 32'd0, 1'b1, "R8 second word reads zero");
    wr(12'h000, KEY, 1'b0, "R6 key without arm");
    check("R6 arm cleared on engage", {31'd0, locked}, 32'd1);
    wr(12'h00C, 32'hFFFF_FFFF, 1'b1, "R7 locked write");
    rd_chk(12'h00C, 32'h0F00_00F0, 1'b0, "R7 dout frozen");
    wr(12'h068, 32'hFFFF_FFFF, 1'b1, "R7 locked alias");
    check("R7 cfg_dout frozen", cfg_dout, 32'h0F00_00F0);
    pulse_hit(32'h0000_0004);
    wr(12'h04C, 32'h0000_0004, 1'b1, "R7 locked w1c");
    check("R7 status kept", evt_status, 32'h0000_0004);
    wr(12'h07C, ARM, 1'b0, "R8 arm");
    wr(12'h000, 32'h0, 1'b0, "R8 wrong key");
    check("R8 still locked", {31'd0, locked}, 32'd1);
    wr(12'h000, KEY, 1'b0, "R8 key after wrong");
    check("R8 unlocked", {31'd0, locked}, 32'd0);
    rd_chk(12'h000, 32'd0, 1'b0, "R8 lock word cleared");
    wr(12'h04C, 32'h0000_0004, 1'b0, "R8 writes allowed again");
    check("R8 status cleared", evt_status, 32'd0);
    wr(12'h000, 32'h0, 1'b0, "R6 engage via first word");
    check("R6 locked again", {31'd0, locked}, 32'd1);
    wr(12'h07C, ARM, 1'b0, "R8 arm 2");
    wr(12'h000, KEY, 1'b0, "R8 key 2");
    check("R8 unlocked 2", {31'd0, locked}, 32'd0);
  endtask

  task automatic t_illegal;
    rd_chk(12'h00A, 32'd0, 1'b1, "R9 misaligned read");
    wr(12'h00E, 32'hFFFF_FFFF, 1'b1, "R9 misaligned write");
    rd_chk(12'h00C, 32'h0F00_00F0, 1'b0, "R9 dout untouched");
    rd_chk(12'h080, 32'd0, 1'b1, "R9 past window");
    rd_chk(12'hFFC, 32'd0, 1'b1, "R9 top word");
    wr(12'h064, 32'h1, 1'b1, "R9 hole write");
    wr(12'h050, 32'hFFFF_FFFF, 1'b0, "R9 per-pin lock write");
    rd_chk(12'h050, 32'd0, 1'b0, "R9 per-pin lock read");
    rd_chk(12'h0FC, 32'd0, 1'b1, "R10 refused read");
    @(negedge clk);
    check("R10 err one cycle", {31'd0, bus_err}, 32'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_alias();
    t_events();
    t_din();
    t_lock();
    t_illegal();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule